// File: doc/BRIEF.md
# Clustered Line Buffer Controller

This block holds the five most recent image rows that a 5x5 pixel window stage needs. Each row store is cut into eight single-port memory clusters along the column axis. Seven clusters hold 512 columns and the last holds 256, so one row spans up to 3840 columns. A writer streams the incoming row into the line that holds the oldest row. A reader fetches one column of all five lines per access. Each cluster belongs to exactly one side at a time. The writer hands a cluster to the reader once it has filled it, and the reader hands it back once it has consumed it. The two streams therefore run concurrently on different clusters without dual-port memory.

A frame-start pulse latches the image width and returns every cluster to the writer. It also clears the line pointers. Clusters wholly beyond the latched width have their clock enable held low and are never accessed. An access at or beyond the width is refused and flagged. Both sides use a valid/ready handshake, so a side that reaches a cluster the other side still owns simply waits.

Top module: `cluster_line_buffer`

## Requirements
- R1: After reset all eight cluster enables are high, the width is 3840, every cluster belongs to the writer (`wr_ready_o` high for column 0, `rd_ready_o` low for column 0), `line_ptr_o` is 0, `acc_err_o` is 0 and `rd_dv_o` is 0.
- R2: Column bits [11:9] select the cluster and bits [8:0] the word inside it. Clusters 0 to 6 hold 512 columns and cluster 7 holds 256. A value written at a column is read back at that same column.
- R3: A cluster is never accessed by both sides in one cycle. When both sides address the same cluster, only the owner sees ready high.
- R4: `wr_ready_o` is low while the addressed cluster belongs to the reader, so the writer stalls and nothing is overwritten.
- R5: A write accepted at offset 511 of its cluster, or at column width-1, gives that cluster to the reader from the next cycle. A read accepted at the same positions gives it back to the writer.
- R6: On `frame_start_i` the width is latched; a width of 0 or above 3840 is taken as 3840. One cycle later `clk_en_o[k]` is high exactly when k < ceil(width/512). A gated cluster is never accessed.
- R7: A valid access at a column >= the latched width drives `acc_err_o` high in the same cycle with that side's ready low.
- R8: `line_ptr_o`, the line the writer fills, advances modulo 5 after the write of column width-1 is accepted. The reader's line order advances likewise after it reads column width-1.
- R9: One cycle after a read is accepted, `rd_dv_o` is high and `rd_win_o` holds the column of all five lines. Byte lane i (bits 8i+7:8i) is row age order, lane 0 oldest and lane 4 the row most recently completed by the writer.
- R10: `frame_start_i` returns all clusters to the writer and sets both line pointers to 0 from the next cycle.
- R11: A write and a read are accepted in the same cycle when they address different clusters each owned by its side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Frame start pulse: latch width, clear ownership and pointers |
| width_i | input | 12 | Image width in columns, sampled on frame_start_i |
| wr_valid_i | input | 1 | Writer request |
| wr_col_i | input | 12 | Writer column |
| wr_data_i | input | 8 | Writer pixel |
| wr_ready_o | output | 1 | Write accepted this cycle when valid |
| rd_valid_i | input | 1 | Reader request |
| rd_col_i | input | 12 | Reader column |
| rd_ready_o | output | 1 | Read accepted this cycle when valid |
| rd_dv_o | output | 1 | Window column valid |
| rd_win_o | output | 40 | Five pixels of one column, oldest row in lane 0 |
| clk_en_o | output | 8 | Per-cluster clock enable |
| acc_err_o | output | 1 | Access beyond the latched width |
| line_ptr_o | output | 3 | Line the writer is filling (oldest row) |

## Verification
Ready and error flags are combinational from the column and the ownership state. The bench drives inputs on the falling edge and reads the flags half a nanosecond later, before the accepting edge. Ownership, line pointer and enable changes appear one cycle after the accepting edge or frame pulse. The window column appears one cycle after the read's accepting edge, so the bench checks it on the falling edge that follows. Expected windows come from a bench memory model keyed by physical line and column. Lanes never written are masked.

// File: rtl/lcb_pkg.sv
`timescale 1ns/1ps
package lcb_pkg;
  // Words held by cluster k: all full-size except the remainder in the last one.
  function automatic int clust_depth(int k, int n_cl, int cl_words, int max_w);
    return (k < n_cl - 1) ? cl_words : max_w - (n_cl - 1) * cl_words;
  endfunction

  function automatic int ring_add(int a, int b, int m);
    return (a + b) % m;
  endfunction
endpackage

// File: rtl/lcb_cluster_ram.sv
`timescale 1ns/1ps
module lcb_cluster_ram #(
  parameter int DEPTH = 512,
  parameter int LANES = 5,
  parameter int PIX_W = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int DW = LANES * PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_en_i,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [LANES-1:0] lane_we_i,
  input  logic [IW-1:0]    addr_i,
  input  logic [PIX_W-1:0] wdata_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  // Behavioural single port; gate_en_i stands in for the gated cluster clock.
  always_ff @(posedge clk_i) begin
    if (gate_en_i && en_i) begin
      if (we_i) begin
        for (int l = 0; l < LANES; l++) begin
          if (lane_we_i[l]) mem[addr_i][l*PIX_W +: PIX_W] <= wdata_i;
        end
      end else begin
        rdata_q <= mem[addr_i];
      end
    end
  end

  assign rdata_o = rdata_q;

  assert_gated_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_en_i |-> !en_i);

  assert_one_lane_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && we_i) |-> ($countones(lane_we_i) == 1));
endmodule

// File: rtl/lcb_owner_flags.sv
`timescale 1ns/1ps
module lcb_owner_flags #(
  parameter int N_CL = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic [N_CL-1:0] give_i,   // writer done -> reader
  input  logic [N_CL-1:0] take_i,   // reader done -> writer
  output logic [N_CL-1:0] owner_o   // 1 = reader owns
);
  logic [N_CL-1:0] owner_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      owner_q <= '0;
    else if (clear_i) owner_q <= '0;
    else              owner_q <= (owner_q | give_i) & ~take_i;
  end

  assign owner_o = owner_q;

  assert_give_from_writer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (give_i & owner_q) == '0);

  assert_take_from_reader_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i & ~owner_q) == '0);

  assert_handover_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((give_i != '0) && !clear_i) |=> ((owner_q & $past(give_i)) == $past(give_i)));

  assert_frame_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (owner_q == '0));
endmodule

// File: rtl/lcb_line_ptr.sv
`timescale 1ns/1ps
module lcb_line_ptr #(
  parameter int N_LINES = 5,
  localparam int PW = $clog2(N_LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          adv_i,
  output logic [PW-1:0] ptr_o
);
  logic [PW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (clear_i) ptr_q <= '0;
    else if (adv_i)   ptr_q <= (ptr_q == PW'(N_LINES - 1)) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  assert_ptr_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q < PW'(N_LINES));

  assert_ptr_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (ptr_q == '0));
endmodule

// File: rtl/cluster_line_buffer.sv
`timescale 1ns/1ps
module cluster_line_buffer
  import lcb_pkg::*;
#(
  parameter int MAX_W    = 3840,
  parameter int CL_WORDS = 512,
  parameter int N_CL     = 8,
  parameter int N_LINES  = 5,
  parameter int PIX_W    = 8,
  localparam int COL_W = $clog2(MAX_W + 1),
  localparam int OFF_W = $clog2(CL_WORDS),
  localparam int CL_W  = $clog2(N_CL),
  localparam int PW    = $clog2(N_LINES),
  localparam int WIN_W = N_LINES * PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic [COL_W-1:0] width_i,
  input  logic             wr_valid_i,
  input  logic [COL_W-1:0] wr_col_i,
  input  logic [PIX_W-1:0] wr_data_i,
  output logic             wr_ready_o,
  input  logic             rd_valid_i,
  input  logic [COL_W-1:0] rd_col_i,
  output logic             rd_ready_o,
  output logic             rd_dv_o,
  output logic [WIN_W-1:0] rd_win_o,
  output logic [N_CL-1:0]  clk_en_o,
  output logic             acc_err_o,
  output logic [PW-1:0]    line_ptr_o
);
  logic [COL_W-1:0] width_q;
  logic [COL_W:0]   n_act;
  logic [N_CL-1:0]  owner, give, take, clk_en;
  logic [CL_W-1:0]  w_cl, r_cl;
  logic [OFF_W-1:0] w_off, r_off;
  logic             w_in, r_in, wr_fire, rd_fire, w_last, r_last, w_row_end, r_row_end;
  logic [PW-1:0]    wr_line, rd_line;
  logic [N_LINES-1:0] lane_we;
  logic [WIN_W-1:0] ram_rd [N_CL];
  logic             rd_dv_q;
  logic [CL_W-1:0]  rd_cl_q;
  logic [PW-1:0]    rd_base_q;

  // Width latch, out-of-range values fall back to the maximum.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) width_q <= COL_W'(MAX_W);
    else if (frame_start_i)
      width_q <= (width_i == '0 || width_i > COL_W'(MAX_W)) ? COL_W'(MAX_W) : width_i;
  end

  assign n_act = ({1'b0, width_q} + (COL_W+1)'(CL_WORDS - 1)) >> OFF_W;

  // Column decode: upper bits pick the cluster, lower bits the word.
  assign w_cl  = wr_col_i[OFF_W +: CL_W];
  assign w_off = wr_col_i[OFF_W-1:0];
  assign r_cl  = rd_col_i[OFF_W +: CL_W];
  assign r_off = rd_col_i[OFF_W-1:0];

  assign w_in = wr_col_i < width_q;
  assign r_in = rd_col_i < width_q;

  assign wr_ready_o = w_in && !owner[w_cl];
  assign rd_ready_o = r_in &&  owner[r_cl];
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign rd_fire    = rd_valid_i && rd_ready_o;
  assign acc_err_o  = (wr_valid_i && !w_in) || (rd_valid_i && !r_in);

  assign w_row_end = wr_col_i == (width_q - COL_W'(1));
  assign r_row_end = rd_col_i == (width_q - COL_W'(1));
  assign w_last    = wr_fire && ((w_off == '1) || w_row_end);
  assign r_last    = rd_fire && ((r_off == '1) || r_row_end);

  always_comb begin
    give = '0;
    take = '0;
    if (w_last) give[w_cl] = 1'b1;
    if (r_last) take[r_cl] = 1'b1;
  end

  lcb_owner_flags #(.N_CL(N_CL)) u_owner (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (frame_start_i),
    .give_i  (give),
    .take_i  (take),
    .owner_o (owner)
  );

  lcb_line_ptr #(.N_LINES(N_LINES)) u_wr_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (frame_start_i),
    .adv_i   (wr_fire && w_row_end),
    .ptr_o   (wr_line)
  );

  lcb_line_ptr #(.N_LINES(N_LINES)) u_rd_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (frame_start_i),
    .adv_i   (rd_fire && r_row_end),
    .ptr_o   (rd_line)
  );

  assign lane_we = N_LINES'(1) << wr_line;

  for (genvar k = 0; k < N_CL; k++) begin : g_cl
    localparam int DEP = clust_depth(k, N_CL, CL_WORDS, MAX_W);
    localparam int IW  = $clog2(DEP);
    logic          sel_w, sel_r;
    logic [IW-1:0] addr_k;

    assign clk_en[k] = n_act > (COL_W+1)'(k);
    assign sel_w     = wr_fire && (w_cl == CL_W'(k));
    assign sel_r     = rd_fire && (r_cl == CL_W'(k));
    assign addr_k    = sel_w ? IW'(w_off) : IW'(r_off);

    lcb_cluster_ram #(.DEPTH(DEP), .LANES(N_LINES), .PIX_W(PIX_W)) u_ram (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .gate_en_i (clk_en[k]),
      .en_i      (sel_w || sel_r),
      .we_i      (sel_w),
      .lane_we_i (lane_we),
      .addr_i    (addr_k),
      .wdata_i   (wr_data_i),
      .rdata_o   (ram_rd[k])
    );
  end

  assign clk_en_o   = clk_en;
  assign line_ptr_o = wr_line;

  // Read return path: remember the cluster and line order at issue.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_dv_q   <= 1'b0;
      rd_cl_q   <= '0;
      rd_base_q <= '0;
    end else begin
      rd_dv_q <= rd_fire;
      if (rd_fire) begin
        rd_cl_q   <= r_cl;
        rd_base_q <= rd_line;
      end
    end
  end

  // Lane 0 = oldest row (base+1), last lane = newest row (base).
  always_comb begin
    logic [WIN_W-1:0] raw;
    int src;
    raw = ram_rd[rd_cl_q];
    for (int i = 0; i < N_LINES; i++) begin
      src = ring_add(int'(rd_base_q), i + 1, N_LINES);
      rd_win_o[i*PIX_W +: PIX_W] = raw[src*PIX_W +: PIX_W];
    end
  end

  assign rd_dv_o = rd_dv_q;

  assert_one_owner_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_fire && rd_fire && (w_cl == r_cl)));

  assert_gated_untouched_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire |-> clk_en_o[w_cl]) and (rd_fire |-> clk_en_o[r_cl]));

  assert_err_refused_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && (wr_col_i >= width_q)) |-> (acc_err_o && !wr_ready_o));

  assert_win_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fire |=> rd_dv_o);

  assert_win_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_fire |=> !rd_dv_o);
endmodule

// File: tb/cluster_line_buffer_tb.sv
`timescale 1ns/1ps
module cluster_line_buffer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [11:0] width = 12'd0;
  logic        wr_valid = 1'b0;
  logic [11:0] wr_col = 12'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        rd_valid = 1'b0;
  logic [11:0] rd_col = 12'd0;
  logic        wr_ready_o, rd_ready_o, rd_dv_o, acc_err_o;
  logic [39:0] rd_win_o;
  logic [7:0]  clk_en_o;
  logic [2:0]  line_ptr_o;

  int errs = 0, checks = 0, conc = 0;
  int mwr = 0, mrd = 0, cur_w = 3840;
  bit done = 1'b0;
  logic [7:0] bm [int];

  always #2 clk = ~clk;

  cluster_line_buffer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame_start), .width_i(width),
    .wr_valid_i(wr_valid), .wr_col_i(wr_col), .wr_data_i(wr_data), .wr_ready_o(wr_ready_o),
    .rd_valid_i(rd_valid), .rd_col_i(rd_col), .rd_ready_o(rd_ready_o),
    .rd_dv_o(rd_dv_o), .rd_win_o(rd_win_o), .clk_en_o(clk_en_o),
    .acc_err_o(acc_err_o), .line_ptr_o(line_ptr_o)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int clamp_w(int w);
    return (w == 0 || w > 3840) ? 3840 : w;
  endfunction

  function automatic logic [7:0] en_mask(int w);
    int n = (clamp_w(w) + 511) / 512;
    return 8'((1 << n) - 1);
  endfunction

  task automatic new_frame(int w);
    @(negedge clk); width = 12'(w); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    mwr = 0; mrd = 0; cur_w = clamp_w(w);
  endtask

  task automatic wr_px(int c);
    bit acc = 1'b0;
    while (!acc) begin
      @(negedge clk); wr_valid = 1'b1; wr_col = 12'(c); wr_data = 8'($urandom);
      #0.5;
      if (wr_ready_o) begin acc = 1'b1; bm[mwr*4096 + c] = wr_data; end
    end
    @(posedge clk);
    if (c == cur_w - 1) mwr = (mwr + 1) % 5;
  endtask

  task automatic wr_stop();
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic rd_px(int c);
    bit acc = 1'b0;
    logic [39:0] e = '0, m = '0;
    while (!acc) begin
      @(negedge clk); rd_valid = 1'b1; rd_col = 12'(c);
      #0.5;
      if (rd_ready_o) begin
        acc = 1'b1;
        for (int i = 0; i < 5; i++) begin
          int key = ((mrd + 1 + i) % 5) * 4096 + c;
          if (bm.exists(key)) begin e[i*8 +: 8] = bm[key]; m[i*8 +: 8] = 8'hFF; end
        end
        if (wr_valid && wr_ready_o) conc++;
      end
    end
    @(negedge clk); rd_valid = 1'b0;
    if (c == cur_w - 1) mrd = (mrd + 1) % 5;
    check(rd_dv_o && ((rd_win_o & m) == (e & m)), "R9 R2 R8 window", rd_win_o, e);
  endtask

  task automatic stream(int rows);
    fork
      begin
        for (int r = 0; r < rows; r++)
          for (int c = 0; c < cur_w; c++) begin
            if ($urandom % 8 == 0) begin @(negedge clk); wr_valid = 1'b0; end
            wr_px(c);
          end
        wr_stop();
      end
      begin
        for (int r = 0; r < rows; r++)
          for (int c = 0; c < cur_w; c++) rd_px(c);
      end
    join
  endtask

  task automatic probe(int wc, int rc);
    @(negedge clk); wr_col = 12'(wc); rd_col = 12'(rc); #0.5;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    probe(0, 0);
    check(clk_en_o == 8'hFF, "R1 clk_en", clk_en_o, 8'hFF);
    check(wr_ready_o == 1'b1, "R1 wr_ready", wr_ready_o, 1);
    check(rd_ready_o == 1'b0, "R1 rd_ready", rd_ready_o, 0);
    check(line_ptr_o == 3'd0, "R1 line_ptr", line_ptr_o, 0);
    check(!acc_err_o && !rd_dv_o, "R1 err/dv", {acc_err_o, rd_dv_o}, 0);

    // R6 gating for width 600
    new_frame(600);
    check(clk_en_o == en_mask(600), "R6 clk_en 600", clk_en_o, en_mask(600));

    // R7 out-of-width access
    @(negedge clk); wr_valid = 1'b1; wr_col = 12'd700; #0.5;
    check(acc_err_o && !wr_ready_o, "R7 write err", {acc_err_o, wr_ready_o}, 2'b10);
    @(negedge clk); wr_valid = 1'b0; rd_valid = 1'b1; rd_col = 12'd600; #0.5;
    check(acc_err_o && !rd_ready_o, "R7 read err", {acc_err_o, rd_ready_o}, 2'b10);
    @(negedge clk); rd_valid = 1'b0;

    // Fill cluster 0 only: R5 handover
    for (int c = 0; c < 512; c++) wr_px(c);
    wr_stop();
    probe(0, 0);
    check(rd_ready_o == 1'b1, "R5 cluster0 to reader", rd_ready_o, 1);
    probe(512, 512);
    check(rd_ready_o == 1'b0, "R5 cluster1 not yet filled", rd_ready_o, 0);
    for (int c = 512; c < 600; c++) wr_px(c);
    wr_stop();
    probe(0, 599);
    check(line_ptr_o == 3'd1, "R8 line_ptr after row", line_ptr_o, 1);
    check(rd_ready_o == 1'b1, "R5 partial last cluster", rd_ready_o, 1);

    // R4 / R3 writer stalls on a reader-owned cluster
    @(negedge clk); wr_valid = 1'b1; wr_col = 12'd0; rd_col = 12'd0; #0.5;
    check(!wr_ready_o, "R4 writer stall", wr_ready_o, 0);
    check(!wr_ready_o && rd_ready_o, "R3 single owner", {wr_ready_o, rd_ready_o}, 2'b01);
    @(negedge clk); wr_valid = 1'b0;

    // R9 / R2 read the row back
    for (int c = 0; c < 600; c++) rd_px(c);
    probe(0, 0);
    check(wr_ready_o == 1'b1, "R5 cluster0 back to writer", wr_ready_o, 1);

    // R10 frame start clears ownership and pointers
    for (int c = 0; c < 512; c++) wr_px(c);
    wr_stop();
    probe(0, 0);
    check(rd_ready_o == 1'b1, "R10 pre: reader owns", rd_ready_o, 1);
    new_frame(600);
    probe(0, 0);
    check(wr_ready_o && !rd_ready_o, "R10 owners cleared", {wr_ready_o, rd_ready_o}, 2'b10);
    check(line_ptr_o == 3'd0, "R10 line_ptr cleared", line_ptr_o, 0);

    // Random streaming frames
    new_frame(0);
    check(clk_en_o == 8'hFF, "R6 width 0 clamps", clk_en_o, 8'hFF);
    stream(6);
    new_frame(1030);
    check(clk_en_o == en_mask(1030), "R6 clk_en 1030", clk_en_o, en_mask(1030));
    stream(6);
    begin
      int w = 1 + int'($urandom % 2000);
      new_frame(w);
      check(clk_en_o == en_mask(w), "R6 clk_en random", clk_en_o, en_mask(w));
      stream(6);
    end
    check(conc > 0, "R11 concurrent write and read", conc, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule